// File: doc/BRIEF.md
# Mixed-Width Register Access Adapter

This block sits between a CPU-side port that issues byte, halfword or word accesses and a register file whose registers each have a fixed native width of one, two or four bytes. A width table, indexed by the offset's 4-byte group, gives every register's native width. The adapter turns each CPU access into one or more native-width accesses to the register file. A narrow read of a wider register becomes one native read, and the addressed lanes are taken out of it. A narrow write to a wider register becomes a native read followed by a native write of the merged value. A wide access over narrower registers becomes a run of native accesses at ascending addresses. All byte ordering is big-endian: the most significant byte sits at the lowest address.

The register file is modelled as a byte-addressed backing store that is reset to zero. The adapter takes one CPU access at a time. `ready` is high while it can accept a request, and a one-cycle `done` pulse marks the end of each access. It carries `err` when the access was refused, and `rdata` then holds the read result.

Top module: `mwa_top`

## Requirements
- R1: Only address bits 9:0 form the register offset; bits above them have no effect on which register is reached.
- R2: An access is refused when its offset exceeds 0x1FF, when it falls in an unmapped group, or when it is not aligned to its own size (size code 0 = byte, 1 = halfword, 2 = word). A refused access leaves the store unchanged, sets `err` with `done` one cycle after acceptance, and returns read data 0.
- R3: Native widths by offset: 0x000–0x02F byte, 0x030–0x03F halfword, 0x040–0x0BF word, 0x0C0–0x0FF unmapped, 0x100–0x13F halfword, 0x140–0x1FF byte.
- R4: A byte read of a wider register uses one native read. It returns the byte that big-endian order places at the addressed offset: the upper byte of a halfword register for an even offset.
- R5: A write narrower than the register takes two native accesses, a read and then a write. Only the addressed bytes change.
- R6: A halfword access to byte registers becomes two byte accesses, and the high byte goes to the lower address.
- R7: A word access becomes two halfword accesses on halfword registers or four byte accesses on byte registers. The most significant part goes to the lowest address.
- R8: A halfword read of a word register returns the upper 16 bits when offset bits 1:0 are 0, and the lower 16 bits otherwise.
- R9: `ready` is high only when idle. `done` is a single-cycle pulse that rises N+1 cycles after the accepting edge, where N is the number of native accesses, and `err` is never high without `done`.
- R10: After reset `ready` is 1, `done` and `err` are 0, and every register reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req | input | 1 | Access request, taken when `ready` is high |
| we | input | 1 | 1 = write, 0 = read |
| size | input | 2 | 0 byte, 1 halfword, 2 word |
| addr | input | ADDR_W | Byte address; bits 9:0 are the offset |
| wdata | input | 32 | Write data, right-aligned |
| ready | output | 1 | Idle and able to accept a request |
| done | output | 1 | One-cycle completion pulse |
| err | output | 1 | Access refused; valid with `done` |
| rdata | output | 32 | Read result, right-aligned, held until the next read |

## Verification
The assertions assume that `req` is only taken while `ready` is high and that request fields are stable in the cycle `req` is sampled. They also assume that every native access the sequencer issues is aligned to its width and lies inside the store, which holds only if the refusal rules filter bad offsets first. The stimulus raises `req` for exactly one cycle, and only after it has seen `ready`. It deliberately sends misaligned, out-of-range and unmapped requests, so the checks on the store's native-access path are exercised against the refusal logic.

// File: rtl/mwa_pkg.sv
package mwa_pkg;
  localparam int OFF_W    = 10;
  localparam int DATA_W   = 32;
  localparam logic [OFF_W-1:0] LAST_OFF = 10'h1FF;

  typedef enum logic [1:0] {ST_IDLE, ST_RUN, ST_FIN} state_e;
  typedef enum logic [1:0] {MODE_EQ, MODE_NARROW, MODE_WIDE} mode_e;

  // Native width in bytes for a 4-byte group (offset[9:2]); 0 = unmapped.
  function automatic logic [2:0] native_width(logic [7:0] grp);
    if (grp <= 8'h0B)      return 3'd1;
    else if (grp <= 8'h0F) return 3'd2;
    else if (grp <= 8'h2F) return 3'd4;
    else if (grp <= 8'h3F) return 3'd0;
    else if (grp <= 8'h4F) return 3'd2;
    else if (grp <= 8'h7F) return 3'd1;
    else                   return 3'd0;
  endfunction

  function automatic logic [DATA_W-1:0] bytes_mask(int nb);
    if (nb >= 4) return '1;
    return (32'h1 << (8 * nb)) - 32'h1;
  endfunction

  // Bit position of a sub-field of nb bytes at byte o inside a w-byte big-endian word.
  function automatic int lane_shift(int o, int nb, int w);
    return 8 * (w - o - nb);
  endfunction

  function automatic logic [DATA_W-1:0] pick_lanes(logic [DATA_W-1:0] v, int o, int nb, int w);
    return (v >> lane_shift(o, nb, w)) & bytes_mask(nb);
  endfunction

  function automatic logic [DATA_W-1:0] merge_lanes(logic [DATA_W-1:0] v, logic [DATA_W-1:0] d,
                                                    int o, int nb, int w);
    int sh;
    sh = lane_shift(o, nb, w);
    return (v & ~(bytes_mask(nb) << sh)) | ((d & bytes_mask(nb)) << sh);
  endfunction

  // Piece k (0 = most significant) of an nb-byte value cut into w-byte pieces.
  function automatic logic [DATA_W-1:0] wide_piece(logic [DATA_W-1:0] d, int k, int nb, int w);
    return (d >> (8 * (nb - (k + 1) * w))) & bytes_mask(w);
  endfunction

  function automatic logic [DATA_W-1:0] wide_gather(logic [DATA_W-1:0] acc, logic [DATA_W-1:0] rd, int w);
    return (acc << (8 * w)) | rd;
  endfunction
endpackage

// File: rtl/mwa_store.sv
module mwa_store
  import mwa_pkg::*;
#(
  parameter int STORE_BYTES = 512
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              be_en,
  input  logic              be_we,
  input  logic [OFF_W-1:0]  be_addr,
  input  logic [2:0]        be_width,
  input  logic [DATA_W-1:0] be_wdata,
  output logic [DATA_W-1:0] be_rdata
);
  localparam int IDX_W = $clog2(STORE_BYTES);

  logic [7:0] mem [STORE_BYTES];
  logic [IDX_W-1:0] base_idx;
  assign base_idx = be_addr[IDX_W-1:0];

  always_comb begin
    be_rdata = '0;
    for (int i = 0; i < 4; i++) begin
      if (i < int'(be_width))
        be_rdata = (be_rdata << 8) | DATA_W'(mem[base_idx + IDX_W'(i)]);
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < STORE_BYTES; i++) mem[i] <= 8'h00;
    end else if (be_en && be_we) begin
      for (int i = 0; i < 4; i++) begin
        if (i < int'(be_width))
          mem[base_idx + IDX_W'(i)] <= 8'(be_wdata >> (8 * (int'(be_width) - 1 - i)));
      end
    end
  end

  // Native accesses stay inside the mapped range (R2) and match their width (R3).
  assert_native_in_range_R2: assert property (@(posedge clk) disable iff (!rst_n)
    be_en |-> (be_addr <= LAST_OFF));
  assert_native_aligned_R3: assert property (@(posedge clk) disable iff (!rst_n)
    be_en |-> ((be_addr & (OFF_W'(be_width) - OFF_W'(1))) == '0));
  assert_native_width_legal_R3: assert property (@(posedge clk) disable iff (!rst_n)
    be_en |-> $onehot(be_width));
endmodule

// File: rtl/mwa_seq.sv
module mwa_seq
  import mwa_pkg::*;
#(
  parameter int ADDR_W = 12
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req,
  input  logic              we,
  input  logic [1:0]        size,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  output logic              ready,
  output logic              done,
  output logic              err,
  output logic [DATA_W-1:0] rdata,
  output logic              be_en,
  output logic              be_we,
  output logic [OFF_W-1:0]  be_addr,
  output logic [2:0]        be_width,
  output logic [DATA_W-1:0] be_wdata,
  input  logic [DATA_W-1:0] be_rdata
);
  state_e            state_q;
  mode_e             mode_q, mode_d;
  logic [OFF_W-1:0]  base_q;
  logic [2:0]        nb_q, w_q, nsteps_q, step_q, nsteps_d;
  logic              we_q, err_q;
  logic [DATA_W-1:0] wdata_q, acc_q, result_q, result_now;

  // Request decode (named for the assertions)
  logic [OFF_W-1:0] off;
  logic [2:0]       req_w, req_nb;
  logic             bad_acc, accept, last_step;
  logic             unused_hi;

  assign unused_hi = ^addr[ADDR_W-1:OFF_W];
  assign off    = addr[OFF_W-1:0];
  assign req_w  = native_width(off[OFF_W-1:2]);
  assign req_nb = (size == 2'd3) ? 3'd0 : (3'd1 << size);
  assign bad_acc = (off > LAST_OFF) || (req_w == 3'd0) || (req_nb == 3'd0) ||
                   ((off & (OFF_W'(req_nb) - OFF_W'(1))) != '0);
  assign ready  = (state_q == ST_IDLE);
  assign accept = req && ready;
  assign done   = (state_q == ST_FIN);
  assign err    = err_q;
  assign rdata  = result_q;

  always_comb begin
    if (req_nb == req_w) begin
      mode_d = MODE_EQ;     nsteps_d = 3'd1;
    end else if (req_nb < req_w) begin
      mode_d = MODE_NARROW; nsteps_d = we ? 3'd2 : 3'd1;
    end else begin
      mode_d = MODE_WIDE;   nsteps_d = (req_w == 3'd0) ? 3'd1 : 3'(int'(req_nb) / int'(req_w));
    end
  end

  // Native access issued in every RUN cycle
  assign be_en     = (state_q == ST_RUN);
  assign be_width  = w_q;
  assign last_step = (step_q == nsteps_q - 3'd1);

  always_comb begin
    be_we    = we_q;
    be_addr  = base_q;
    be_wdata = wdata_q;
    case (mode_q)
      MODE_NARROW: begin
        be_we    = we_q && (step_q == 3'd1);
        be_addr  = base_q & ~(OFF_W'(w_q) - OFF_W'(1));
        be_wdata = merge_lanes(acc_q, wdata_q, int'(base_q[1:0] & (w_q[1:0] - 2'd1)),
                               int'(nb_q), int'(w_q));
      end
      MODE_WIDE: begin
        be_addr  = base_q + OFF_W'(int'(step_q) * int'(w_q));
        be_wdata = wide_piece(wdata_q, int'(step_q), int'(nb_q), int'(w_q));
      end
      default: ;
    endcase
  end

  always_comb begin
    case (mode_q)
      MODE_NARROW: result_now = pick_lanes(be_rdata, int'(base_q[1:0] & (w_q[1:0] - 2'd1)),
                                           int'(nb_q), int'(w_q));
      MODE_WIDE:   result_now = wide_gather(acc_q, be_rdata, int'(w_q));
      default:     result_now = be_rdata;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q  <= ST_IDLE;
      mode_q   <= MODE_EQ;
      base_q   <= '0;
      nb_q     <= 3'd1;
      w_q      <= 3'd1;
      nsteps_q <= 3'd1;
      step_q   <= '0;
      we_q     <= 1'b0;
      err_q    <= 1'b0;
      wdata_q  <= '0;
      acc_q    <= '0;
      result_q <= '0;
    end else begin
      case (state_q)
        ST_IDLE: if (req) begin
          state_q <= bad_acc ? ST_FIN : ST_RUN;
          err_q   <= bad_acc;
          if (bad_acc) result_q <= '0;
          mode_q   <= mode_d;
          base_q   <= off;
          nb_q     <= req_nb;
          w_q      <= req_w;
          nsteps_q <= nsteps_d;
          we_q     <= we;
          wdata_q  <= wdata;
          step_q   <= '0;
          acc_q    <= '0;
        end
        ST_RUN: begin
          step_q <= step_q + 3'd1;
          if (mode_q == MODE_WIDE)    acc_q <= wide_gather(acc_q, be_rdata, int'(w_q));
          else if (step_q == 3'd0)    acc_q <= be_rdata;
          if (last_step) begin
            state_q <= ST_FIN;
            if (!we_q) result_q <= result_now;
          end
        end
        default: begin
          state_q <= ST_IDLE;
          err_q   <= 1'b0;
        end
      endcase
    end
  end

  assert_accept_busy_R9: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> !ready);
  assert_done_pulse_R9: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  assert_err_with_done_R9: assert property (@(posedge clk) disable iff (!rst_n)
    err |-> done);
  assert_last_step_done_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (be_en && last_step) |=> (done && !err));
  assert_refused_no_access_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (done && err) |-> !$past(be_en));
  assert_refused_on_bad_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && bad_acc) |=> (done && err));
endmodule

// File: rtl/mwa_top.sv
module mwa_top
  import mwa_pkg::*;
#(
  parameter int ADDR_W      = 12,
  parameter int STORE_BYTES = 512
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req,
  input  logic              we,
  input  logic [1:0]        size,
  input  logic [ADDR_W-1:0] addr,
  input  logic [31:0]       wdata,
  output logic              ready,
  output logic              done,
  output logic              err,
  output logic [31:0]       rdata
);
  logic              be_en, be_we;
  logic [OFF_W-1:0]  be_addr;
  logic [2:0]        be_width;
  logic [DATA_W-1:0] be_wdata, be_rdata;

  mwa_seq #(.ADDR_W(ADDR_W)) u_seq (
    .clk(clk), .rst_n(rst_n), .req(req), .we(we), .size(size), .addr(addr),
    .wdata(wdata), .ready(ready), .done(done), .err(err), .rdata(rdata),
    .be_en(be_en), .be_we(be_we), .be_addr(be_addr), .be_width(be_width),
    .be_wdata(be_wdata), .be_rdata(be_rdata)
  );

  mwa_store #(.STORE_BYTES(STORE_BYTES)) u_store (
    .clk(clk), .rst_n(rst_n), .be_en(be_en), .be_we(be_we), .be_addr(be_addr),
    .be_width(be_width), .be_wdata(be_wdata), .be_rdata(be_rdata)
  );
endmodule

// File: tb/test_mwa_top.sv
module test_mwa_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req = 1'b0, we = 1'b0;
  logic [1:0]  size = 2'd0;
  logic [11:0] addr = '0;
  logic [31:0] wdata = '0;
  logic        ready, done, err;
  logic [31:0] rdata;

  int checks = 0, fails = 0, cyc = 0;
  logic [7:0]  model [512];
  logic [31:0] last_rd = '0;

  always #10 clk = ~clk;

  mwa_top i_mwa_top (.clk(clk), .rst_n(rst_n), .req(req), .we(we), .size(size), .addr(addr),
                     .wdata(wdata), .ready(ready), .done(done), .err(err), .rdata(rdata));

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > 100000) begin
      fails = fails + 1; checks = checks + 1;
      $display("FAIL watchdog: actual=hung expected=finish");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // Native width restated from the address map in R3
  function automatic int map_width(int o);
    if (o < 'h030) return 1;
    if (o < 'h040) return 2;
    if (o < 'h0C0) return 4;
    if (o < 'h100) return 0;
    if (o < 'h140) return 2;
    if (o < 'h200) return 1;
    return 0;
  endfunction

  task automatic acc(string tag, bit w, int sz, logic [11:0] a, logic [31:0] wd);
    int o, nb, mw, nops, cycles;
    bit experr;
    logic [31:0] exp;
    o = int'(a[9:0]); nb = 1 << sz; mw = map_width(o);
    experr = (o > 'h1FF) || (mw == 0) || (o % nb != 0);
    if (experr) nops = 0;
    else if (nb == mw) nops = 1;
    else if (nb < mw) nops = w ? 2 : 1;
    else nops = nb / mw;
    exp = last_rd;
    if (experr) exp = 0;
    else if (w) for (int i = 0; i < nb; i++) model[o + i] = 8'(wd >> (8 * (nb - 1 - i)));
    else begin
      exp = 0;
      for (int i = 0; i < nb; i++) exp = (exp << 8) | 32'(model[o + i]);
    end
    while (!ready) @(negedge clk);
    req = 1'b1; we = w; size = 2'(sz); addr = a; wdata = wd;
    @(negedge clk);
    req = 1'b0;
    cycles = 1;
    while (!done && cycles < 20) begin @(negedge clk); cycles++; end
    check({tag, " err"}, 32'(err), 32'(experr));
    check({tag, " latency"}, 32'(cycles), 32'(nops + 1));
    check({tag, " rdata"}, rdata, exp);
    last_rd = exp;
    @(negedge clk);
    check({tag, " R9 done is a pulse"}, {30'd0, done, ready}, 32'd1);
  endtask

  task automatic t_reset();
    check("R10 ready after reset", {30'd0, ready, done}, 32'd2);
    check("R10 err after reset", 32'(err), 32'd0);
    acc("R10 word reads zero", 0, 2, 12'h040, 0);
    acc("R10 byte reads zero", 0, 0, 12'h1FF, 0);
  endtask

  task automatic t_byte_regs();
    acc("R7 word to byte regs", 1, 2, 12'h010, 32'hA1B2C3D4);
    acc("R7 msb at low address", 0, 0, 12'h010, 0);
    acc("R7 lsb at high address", 0, 0, 12'h013, 0);
    acc("R6 half to byte regs", 1, 1, 12'h020, 32'h1234);
    acc("R6 high byte low addr", 0, 0, 12'h020, 0);
    acc("R6 low byte", 0, 0, 12'h021, 0);
    acc("R6 half read of byte regs", 0, 1, 12'h012, 0);
  endtask

  task automatic t_half_regs();
    acc("R7 word to half regs", 1, 2, 12'h030, 32'hCAFEBEEF);
    acc("R7 upper half", 0, 1, 12'h030, 0);
    acc("R7 lower half", 0, 1, 12'h032, 0);
    acc("R4 odd byte of half reg", 0, 0, 12'h031, 0);
    acc("R4 even byte of half reg", 0, 0, 12'h032, 0);
    acc("R5 byte write to half reg", 1, 0, 12'h032, 32'h55);
    acc("R5 neighbour kept", 0, 1, 12'h032, 0);
  endtask

  task automatic t_word_regs();
    acc("R3 word reg write", 1, 2, 12'h044, 32'h11223344);
    acc("R8 upper half of word", 0, 1, 12'h044, 0);
    acc("R8 lower half of word", 0, 1, 12'h046, 0);
    acc("R4 byte 3 of word", 0, 0, 12'h047, 0);
    acc("R4 byte 1 of word", 0, 0, 12'h045, 0);
    acc("R5 half write to word", 1, 1, 12'h046, 32'hABCD);
    acc("R5 byte write to word", 1, 0, 12'h044, 32'h99);
    acc("R5 word after merges", 0, 2, 12'h044, 0);
  endtask

  task automatic t_high_regions();
    acc("R3 word to half region", 1, 2, 12'h100, 32'h01020304);
    acc("R3 byte of half region", 0, 0, 12'h103, 0);
    acc("R3 half to top byte regs", 1, 1, 12'h1FE, 32'hBEAD);
    acc("R3 top byte", 0, 0, 12'h1FF, 0);
  endtask

  task automatic t_mask();
    acc("R1 upper bits ignored read", 0, 2, 12'h444, 0);
    acc("R1 upper bits ignored write", 1, 0, 12'hC13, 32'h77);
    acc("R1 aliased byte", 0, 0, 12'h013, 0);
  endtask

  task automatic t_errors();
    acc("R2 unmapped read", 0, 2, 12'h0C0, 0);
    acc("R2 unmapped write", 1, 1, 12'h0C4, 32'hFFFF);
    acc("R2 misaligned half", 1, 1, 12'h031, 32'h0000);
    acc("R2 offset 0x200", 0, 0, 12'h200, 0);
    acc("R2 offset 0x3FC", 1, 2, 12'h3FC, 32'hDEADBEEF);
    acc("R2 misaligned word", 1, 2, 12'h042, 32'h0);
    acc("R2 store untouched", 0, 2, 12'h030, 0);
    acc("R2 word store untouched", 0, 2, 12'h040, 0);
  endtask

  initial begin
    for (int i = 0; i < 512; i++) model[i] = 8'h00;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_byte_regs();
    t_half_regs();
    t_word_regs();
    t_high_regions();
    t_mask();
    t_errors();
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule